// File: doc/BRIEF.md
# Guarded Oscillator Trim Register

This block keeps the 8-bit code that tunes an on-chip oscillator and puts that code on an output port. The code is a signed two's-complement value. Frequency rises steadily from 0x80 (slowest) through 0xFF, 0x00 and 0x01 up to 0x7F (fastest).

As soon as reset ends, the block asks a nonvolatile store for the factory trim word with a single-cycle request. It copies the word into the trim register when the store answers with a valid strobe. Software then sees three byte-wide registers on a simple write-strobe bus with combinational read data. Before software can change the trim, it has to open a chain of guards: a master protect bit, an enable bit that can only be changed through that protect bit together with a qualifier bit written as 0, and a lock bit that overrides every other guard. A trim write that any guard blocks is dropped and leaves a sticky flag behind.

Register map: address 0 is the guard register (bit 0 protect, bit 1 lock, bit 7 reject flag). Address 1 is the enable register (bit 4 enable, bit 6 qualifier, bits 3..0 reserved). Address 2 is the trim register. Address 3 reads as 0x00.

Top module: `osc_trim_regs`

## Requirements
- R1: A write to address 1 with bit 4 = 1 and bit 6 = 0 sets the enable bit, provided the protect bit (address 0 bit 0) is 1 at the time of the write.
- R2: A write to address 1 with bit 4 = 0 and bit 6 = 0 clears the enable bit, provided the protect bit is 1. Reset also clears the enable bit.
- R3: A write to address 1 while the protect bit is 0, or with bit 6 = 1, leaves the enable bit unchanged.
- R4: A bus write to address 2 updates the trim register only when the lock bit (address 0 bit 1) is 0, the enable bit is 1 and the reset-time load has finished. In every other case the trim register keeps its value.
- R5: Reading address 1 returns 1 in bits 3..0, the enable bit in bit 4, and 0 in bits 7, 6 and 5. The qualifier bit is never stored.
- R6: During reset the trim register and `oscTrim` are 0x00. `nvReq` is high for exactly the first cycle after reset is released. `nvValid` in any later cycle, up to and including the first one, loads `nvData` into the trim register.
- R7: Bus writes to address 2 are ignored until the load response arrives. If a bus write to address 2 and the first `nvValid` fall in the same cycle, the stored value is `nvData`.
- R8: `oscTrim` always equals the trim register and shows a written value right after the clock edge that performs the write.
- R9: Any blocked write to address 2 sets the reject flag (address 0 bit 7). Writing address 0 with bit 7 = 1 clears the flag.
- R10: The guard register resets to 0x00. Bits 0 and 1 take the written data on every write to address 0 and read back as written. Bits 6..2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, one write per cycle |
| busRdata | output | 8 | Read data for `busAddr`, combinational |
| nvReq | output | 1 | Single-cycle request for the stored trim word |
| nvValid | input | 1 | Trim word valid from the nonvolatile store |
| nvData | input | 8 | Stored trim word |
| oscTrim | output | 8 | Signed trim code to the oscillator |

## Verification
Two functions can fall in the same cycle: the reset-time load response and a software write to the trim register. The bench raises `nvValid` on the same clock edge as a bus write to address 2 that carries a different value. It passes only if the loaded word appears on `oscTrim` straight after that edge and the reject flag shows that the bus write was dropped. It also checks that the reject flag and its software clear never collide: setting needs a write to address 2, clearing needs a write to address 0, so both cannot occur in one cycle.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  // register addresses; the guard/enable/trim order is the bus contract
  localparam int unsigned ADDR_GUARD  = 0;
  localparam int unsigned ADDR_ENABLE = 1;
  localparam int unsigned ADDR_TRIM   = 2;

  // guard register fields
  localparam int unsigned BIT_PROTECT = 0;
  localparam int unsigned BIT_LOCK    = 1;
  localparam int unsigned BIT_REJECT  = 7;

  // enable register fields
  localparam int unsigned BIT_ENABLE  = 4;
  localparam int unsigned BIT_QUAL    = 6;
  localparam int unsigned RSV_W       = 4;

  typedef enum logic [1:0] {
    LD_REQ  = 2'd0,
    LD_WAIT = 2'd1,
    LD_DONE = 2'd2
  } load_state_e;

  typedef struct packed {
    logic trimWr;     // accepted software write to trim
    logic trimLoad;   // reset-time load from nonvolatile store
    logic rejectSet;  // blocked software write to trim
    logic rejectClr;  // software clear of the reject flag
  } trim_strobe_t;

endpackage

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [TRIM_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              nvValid,
  output logic              nvReq,
  output logic              protectEn,
  output logic              lockBit,
  output logic              trimEn,
  output logic              loadDone,
  output trim_strobe_t      strobe
);

  load_state_e loadState;
  load_state_e loadNext;

  logic guardHit;
  logic enableHit;
  logic trimHit;
  logic enableUpdate;
  logic trimAllowed;

  assign guardHit  = busWe && (busAddr == ADDR_W'(ADDR_GUARD));
  assign enableHit = busWe && (busAddr == ADDR_W'(ADDR_ENABLE));
  assign trimHit   = busWe && (busAddr == ADDR_W'(ADDR_TRIM));

  // enable may change only through the protect bit with the qualifier at 0
  assign enableUpdate = enableHit && protectEn && !busWdata[BIT_QUAL];

  // reset-time load sequencer
  always_comb begin
    loadNext = loadState;
    unique case (loadState)
      LD_REQ:  loadNext = LD_WAIT;
      LD_WAIT: if (nvValid) loadNext = LD_DONE;
      LD_DONE: loadNext = LD_DONE;
      default: loadNext = LD_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadState <= LD_REQ;
    else       loadState <= loadNext;
  end

  assign nvReq    = (loadState == LD_REQ);
  assign loadDone = (loadState == LD_DONE);

  // guard register: protect and lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protectEn <= 1'b0;
      lockBit   <= 1'b0;
    end else if (guardHit) begin
      protectEn <= busWdata[BIT_PROTECT];
      lockBit   <= busWdata[BIT_LOCK];
    end
  end

  // trim write enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             trimEn <= 1'b0;
    else if (enableUpdate) trimEn <= busWdata[BIT_ENABLE];
  end

  assign trimAllowed = loadDone && !lockBit && trimEn;

  always_comb begin
    strobe           = '0;
    strobe.trimLoad  = (loadState == LD_WAIT) && nvValid;
    strobe.trimWr    = trimHit && trimAllowed;
    strobe.rejectSet = trimHit && !trimAllowed;
    strobe.rejectClr = guardHit && busWdata[BIT_REJECT];
  end

endmodule

// File: rtl/osc_trim_data.sv
module osc_trim_data
  import osc_trim_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [TRIM_W-1:0] busWdata,
  input  logic [TRIM_W-1:0] nvData,
  input  trim_strobe_t      strobe,
  input  logic              protectEn,
  input  logic              lockBit,
  input  logic              trimEn,
  output logic              rejectFlag,
  output logic [TRIM_W-1:0] busRdata,
  output logic [TRIM_W-1:0] oscTrim
);

  logic [TRIM_W-1:0] trimReg;
  logic [TRIM_W-1:0] guardView;
  logic [TRIM_W-1:0] enableView;

  // the load response takes priority over any software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               trimReg <= '0;
    else if (strobe.trimLoad) trimReg <= nvData;
    else if (strobe.trimWr)   trimReg <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rejectFlag <= 1'b0;
    else if (strobe.rejectSet) rejectFlag <= 1'b1;
    else if (strobe.rejectClr) rejectFlag <= 1'b0;
  end

  // no staging register: the code reaches the oscillator straight away
  assign oscTrim = trimReg;

  always_comb begin
    guardView              = '0;
    guardView[BIT_PROTECT] = protectEn;
    guardView[BIT_LOCK]    = lockBit;
    guardView[BIT_REJECT]  = rejectFlag;
  end

  always_comb begin
    enableView             = '0;
    enableView[RSV_W-1:0]  = '1;
    enableView[BIT_ENABLE] = trimEn;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_W'(ADDR_GUARD):  busRdata = guardView;
      ADDR_W'(ADDR_ENABLE): busRdata = enableView;
      ADDR_W'(ADDR_TRIM):   busRdata = trimReg;
      default:              busRdata = '0;
    endcase
  end

endmodule

// File: rtl/osc_trim_regs.sv
module osc_trim_regs
  import osc_trim_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [TRIM_W-1:0] busWdata,
  input  logic              busWe,
  output logic [TRIM_W-1:0] busRdata,
  output logic              nvReq,
  input  logic              nvValid,
  input  logic [TRIM_W-1:0] nvData,
  output logic [TRIM_W-1:0] oscTrim
);

  trim_strobe_t strobe;
  logic protectEn;
  logic lockBit;
  logic trimEn;
  logic loadDone;
  logic rejectFlag;

  osc_trim_ctrl #(.ADDR_W(ADDR_W), .TRIM_W(TRIM_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busWe     (busWe),
    .nvValid   (nvValid),
    .nvReq     (nvReq),
    .protectEn (protectEn),
    .lockBit   (lockBit),
    .trimEn    (trimEn),
    .loadDone  (loadDone),
    .strobe    (strobe)
  );

  osc_trim_data #(.ADDR_W(ADDR_W), .TRIM_W(TRIM_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .nvData     (nvData),
    .strobe     (strobe),
    .protectEn  (protectEn),
    .lockBit    (lockBit),
    .trimEn     (trimEn),
    .rejectFlag (rejectFlag),
    .busRdata   (busRdata),
    .oscTrim    (oscTrim)
  );

endmodule

// File: rtl/osc_trim_chk.sv
module osc_trim_chk
  import osc_trim_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned TRIM_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [TRIM_W-1:0] busWdata,
  input logic              busWe,
  input logic [TRIM_W-1:0] busRdata,
  input logic              nvReq,
  input logic              nvValid,
  input logic [TRIM_W-1:0] oscTrim,
  input logic              protectEn,
  input logic              lockBit,
  input logic              trimEn,
  input logic              loadDone,
  input logic              rejectFlag
);

  logic enWr;
  logic trimWrite;
  logic trimBlocked;

  assign enWr        = busWe && (busAddr == ADDR_W'(ADDR_ENABLE));
  assign trimWrite   = busWe && (busAddr == ADDR_W'(ADDR_TRIM));
  assign trimBlocked = trimWrite && (lockBit || !trimEn || !loadDone);

  assert_en_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && protectEn && busWdata[BIT_ENABLE] && !busWdata[BIT_QUAL]) |=> trimEn);

  assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && protectEn && !busWdata[BIT_ENABLE] && !busWdata[BIT_QUAL]) |=> !trimEn);

  assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(enWr && protectEn && !busWdata[BIT_QUAL]) |=> $stable(trimEn));

  assert_trim_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (trimWrite && loadDone && (lockBit || !trimEn)) |=> $stable(oscTrim));

  assert_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(ADDR_ENABLE)) |-> (busRdata[RSV_W-1:0] == '1 && !busRdata[BIT_QUAL]));

  assert_nvreq_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    nvReq |=> !nvReq);

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trimWrite && !loadDone && !nvValid) |=> $stable(oscTrim));

  assert_write_now_R8: assert property (@(posedge clk) disable iff (!rstN)
    (trimWrite && loadDone && !lockBit && trimEn) |=> (oscTrim == $past(busWdata)));

  assert_reject_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    trimBlocked |=> rejectFlag);

endmodule

bind osc_trim_regs osc_trim_chk #(.ADDR_W(ADDR_W), .TRIM_W(TRIM_W)) u_chk (.*);

// File: tb/osc_trim_regs_tb.sv
module osc_trim_regs_tb;

  localparam int unsigned ADDR_W = 2;
  localparam int unsigned TRIM_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [TRIM_W-1:0] busWdata = '0;
  logic              busWe = 1'b0;
  logic [TRIM_W-1:0] busRdata;
  logic              nvReq;
  logic              nvValid = 1'b0;
  logic [TRIM_W-1:0] nvData = '0;
  logic [TRIM_W-1:0] oscTrim;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    bit                isOsc;
    logic [TRIM_W-1:0] exp;
    string             tag;
  } item_t;

  item_t sbq[$];

  always #4 clk = ~clk;  // 125 MHz

  osc_trim_regs #(.ADDR_W(ADDR_W), .TRIM_W(TRIM_W)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .nvReq(nvReq), .nvValid(nvValid),
    .nvData(nvData), .oscTrim(oscTrim)
  );

  task automatic compare(input logic [TRIM_W-1:0] got, input logic [TRIM_W-1:0] exp,
                         input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // monitor: pops expected items after each edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        compare(it.isOsc ? oscTrim : busRdata, it.exp, it.tag);
      end
    end
  end

  task automatic expectRead(input int a, input logic [TRIM_W-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    busWe = 1'b0;
    busAddr = ADDR_W'(a);
    it.isOsc = 1'b0; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic expectOsc(input logic [TRIM_W-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.isOsc = 1'b1; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic busWrite(input int a, input logic [TRIM_W-1:0] d);
    @(negedge clk);
    busAddr = ADDR_W'(a);
    busWdata = d;
    busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  // trim write with the oscillator output judged right after the writing edge
  task automatic trimWriteNow(input logic [TRIM_W-1:0] d, input logic [TRIM_W-1:0] exp,
                              input string tag);
    item_t it;
    @(negedge clk);
    busAddr = ADDR_W'(2);
    busWdata = d;
    busWe = 1'b1;
    it.isOsc = 1'b1; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state
    expectRead(2, 8'h00, "R6 trim in reset");
    expectOsc(8'h00, "R6 osc in reset");
    expectRead(1, 8'h0F, "R5 enable reg reset");
    expectRead(0, 8'h00, "R10 guard reset");
    @(negedge clk);
    rstN = 1'b1;
    #1 compare({7'd0, nvReq}, 8'h01, "R6 nvReq after release");
    @(negedge clk);
    compare({7'd0, nvReq}, 8'h00, "R6 nvReq single cycle");

    // open guards, but the load has not arrived yet
    busWrite(0, 8'h01);
    expectRead(0, 8'h01, "R10 protect readback");
    busWrite(1, 8'h10);
    expectRead(1, 8'h1F, "R1 enable set");
    busWrite(2, 8'h33);
    expectOsc(8'h00, "R7 write before load ignored");
    expectRead(0, 8'h81, "R9 reject after early write");
    busWrite(0, 8'h81);
    expectRead(0, 8'h01, "R9 reject cleared");

    // load response and bus write in the same cycle
    @(negedge clk);
    busAddr = ADDR_W'(2); busWdata = 8'h44; busWe = 1'b1;
    nvValid = 1'b1; nvData = 8'hA5;
    expectOsc(8'hA5, "R7 load wins collision");
    busWe = 1'b0; nvValid = 1'b0;
    expectRead(2, 8'hA5, "R6 loaded value");
    expectRead(0, 8'h81, "R7 colliding write rejected");
    busWrite(0, 8'h81);

    // accepted writes, immediate effect
    trimWriteNow(8'h7F, 8'h7F, "R8 write max code");
    expectRead(2, 8'h7F, "R4 accepted write readback");
    expectRead(0, 8'h01, "R9 no reject on accepted write");

    // lock overrides
    busWrite(0, 8'h03);
    expectRead(0, 8'h03, "R10 lock readback");
    busWrite(2, 8'h12);
    expectOsc(8'h7F, "R4 lock blocks write");
    expectRead(0, 8'h83, "R9 reject under lock");
    busWrite(0, 8'h81);
    expectRead(0, 8'h01, "R9 clear and unlock");

    // enable clear, then blocked
    busWrite(1, 8'h00);
    expectRead(1, 8'h0F, "R2 enable cleared");
    busWrite(2, 8'h22);
    expectOsc(8'h7F, "R4 disabled write blocked");

    // qualifier set or protect off: enable holds
    busWrite(1, 8'h50);
    expectRead(1, 8'h0F, "R3 qualifier blocks set");
    busWrite(0, 8'h00);
    busWrite(1, 8'h10);
    expectRead(1, 8'h0F, "R3 protect off blocks set");
    busWrite(0, 8'h01);
    busWrite(1, 8'h10);
    expectRead(1, 8'h1F, "R1 enable set again");
    busWrite(1, 8'h40);
    expectRead(1, 8'h1F, "R3 qualifier blocks clear");
    busWrite(0, 8'h00);
    busWrite(1, 8'h00);
    expectRead(1, 8'h1F, "R3 protect off blocks clear");

    // enable still set with protect off: minimum code accepted
    trimWriteNow(8'h80, 8'h80, "R8 write min code");
    expectRead(3, 8'h00, "R10 unused address");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule